// File: doc/BRIEF.md
# Eight-bit Timer with Compare-Clear Mode

This block is an up-counting timer with an eight-bit counter, two compare channels and one mode bit. The counter moves forward by one on each cycle in which the timer clock enable strobe is high. In free-running mode it counts through the whole range and wraps from 0xFF to 0x00. In clear-on-compare mode, compare channel A sets the top value. The counter returns to zero on the tick that finds it equal to channel A, so the period is A+1 ticks. Channel B only ever raises its own flag.

Software reaches the block through a simple write port that selects the counter, a compare register or the control register. A write to the counter loads the value at once and masks compare detection for the next timer tick. As a result, loading a value equal to a compare register never produces a match. Overflow and compare events set sticky flags. A flag clears through a write-one clear input or an interrupt acknowledge. Each flag is gated by its enable bit to form an interrupt request.

Top module: `tmr8_cc`

## Requirements
- R1: In free-running mode (control bit 0 = 0) each cycle with `tick_en` high increments `count` by one, wrapping 0xFF to 0x00. Without `tick_en` and without a counter write, `count` holds.
- R2: `ovf_flag` (flag index 0) is set on the same clock edge at which `count` rolls from 0xFF to 0x00 by counting, in either mode. This includes compare-clear mode with channel A at 0xFF, and a counter written above channel A. It never sets on a counter write.
- R3: In compare-clear mode (control bit 0 = 1), a tick that finds `count` equal to compare A loads zero instead of incrementing, giving a period of A+1 ticks.
- R4: On a non-blocked tick, compare channel i sets `cmp_flag[i]` (flag index 1+i) when the pre-tick `count` equals compare register i. Channel B (i = 1) never clears the counter.
- R5: A counter write (`wr_addr` = 0) loads `wr_data` into `count` on that edge and takes priority over a simultaneous tick and clear. That cycle raises no compare or overflow event.
- R6: After a counter write, the next tick (however many cycles later) has compare detection masked. It sets no compare flag and performs no clear, and `count` increments instead.
- R7: A one on `flag_clr[j]` or `irq_ack[j]` clears flag j (0 overflow, 1 compare A, 2 compare B). If hardware sets a flag in the same cycle, the set wins. Flags are sticky otherwise.
- R8: `irq_req[j]` is high exactly when flag j is set and its enable bit is set. The enable bits are control bit 1 (overflow), control bit 2 (compare A) and control bit 3 (compare B).
- R9: The write map is: address 1 = compare A, 2 = compare B, 3 = control. A compare or control write is used from the next cycle.
- R10: After reset, `count`, all flags, all compare registers, the control register and `irq_req` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Timer clock enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 counter, 1 A, 2 B, 3 control) |
| wr_data | input | 8 | Write data |
| flag_clr | input | 3 | Write-one flag clear per flag |
| irq_ack | input | 3 | Interrupt acknowledge per flag |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 2 | Compare flags, bit 0 = A, bit 1 = B |
| irq_req | output | 3 | Interrupt requests, index as flags |

## Verification
The bench sweeps compare-clear mode over top values 0, 1, 2, 7, 0x80, 0xFE and 0xFF against an arithmetic model. A design off by one in the clear point would show a period of A or A+2, and a design that forgot the overflow at A = 0xFF would leave the flag low. It loads the counter with values equal to each compare register, both with and without idle cycles before the next tick. A design that did not mask the next tick would raise a flag, or clear the counter early in compare-clear mode. It also checks a write colliding with a tick and a flag set colliding with a clear. Wrong priority shows as a counter that moved past the written value or as a lost flag.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

   typedef enum logic {
      MODE_FREE = 1'b0,
      MODE_CTC  = 1'b1
   } tmr_mode_e;

   localparam int CTRL_MODE_BIT   = 0;
   localparam int CTRL_IE_BASE    = 1;
   localparam int ADDR_COUNTER    = 0;
   localparam int ADDR_CMP_BASE   = 1;

   function automatic int cmp_addr(input int ch);
      return ADDR_CMP_BASE + ch;
   endfunction

   function automatic int ctrl_addr(input int n_cmp);
      return ADDR_CMP_BASE + n_cmp;
   endfunction

endpackage

// File: rtl/tmr8_regfile.sv
module tmr8_regfile
   import tmr8_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int NUM_CMP = 2,
   parameter int ADDR_W  = 2,
   localparam int NUM_SRC = NUM_CMP + 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [ADDR_W-1:0]                wr_addr,
   input  logic [CNT_W-1:0]                 wr_data,
   output logic [NUM_CMP-1:0][CNT_W-1:0]    cmp_val,
   output tmr_mode_e                        mode,
   output logic [NUM_SRC-1:0]               irq_en,
   output logic                             cnt_wr
);

   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(ADDR_COUNTER);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_addr(NUM_CMP));

   logic ctrl_wr;

   assign cnt_wr  = wr_en && (wr_addr == A_CNT);
   assign ctrl_wr = wr_en && (wr_addr == A_CTRL);

   // compare registers, one per channel
   for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp_reg
      localparam logic [ADDR_W-1:0] A_ME = ADDR_W'(cmp_addr(i));
      logic [CNT_W-1:0] val_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            val_q <= '0;
         else if (wr_en && (wr_addr == A_ME))
            val_q <= wr_data;
      end
      assign cmp_val[i] = val_q;
   end

   // control register: mode bit plus one enable per flag
   logic                 mode_q;
   logic [NUM_SRC-1:0]   ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         ie_q   <= '0;
      end else if (ctrl_wr) begin
         mode_q <= wr_data[CTRL_MODE_BIT];
         ie_q   <= wr_data[CTRL_IE_BASE +: NUM_SRC];
      end
   end

   assign mode   = tmr_mode_e'(mode_q);
   assign irq_en = ie_q;

   // R9: a control write is visible on the next cycle
   p_ctrl_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (mode_q == $past(wr_data[CTRL_MODE_BIT])));

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              cnt_wr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              clear_req,
   output logic [CNT_W-1:0]  cnt_q,
   output logic              blk_q,
   output logic              adv,
   output logic              ovf_evt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_d;

   // a tick only counts when no software write owns the cycle
   assign adv     = tick_en && !cnt_wr;
   assign ovf_evt = adv && (cnt_q == CNT_MAX);

   always_comb begin
      cnt_d = cnt_q;
      if (cnt_wr)
         cnt_d = wr_data;
      else if (adv)
         cnt_d = clear_req ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         blk_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         if (cnt_wr)
            blk_q <= 1'b1;
         else if (adv)
            blk_q <= 1'b0;
      end
   end

   // R1: no tick, no write -> counter holds
   p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !cnt_wr) |=> $stable(cnt_q));

   // R1: the top value always leads to zero on a counting tick
   p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && cnt_q == CNT_MAX) |=> (cnt_q == '0));

   // R5: a write lands regardless of tick
   p_write_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(wr_data)));

   // R6: mask stays armed until a counting tick
   p_mask_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_q && !tick_en) |=> blk_q);

endmodule

// File: rtl/tmr8_match.sv
module tmr8_match
   import tmr8_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int NUM_CMP  = 2,
   parameter int CLEAR_CH = 0
) (
   input  logic                           adv,
   input  logic                           blk,
   input  logic [CNT_W-1:0]               cnt,
   input  logic [NUM_CMP-1:0][CNT_W-1:0]  cmp_val,
   input  tmr_mode_e                      mode,
   output logic [NUM_CMP-1:0]             cmp_evt,
   output logic                           clear_req
);

   logic live;

   assign live = adv && !blk;

   for (genvar i = 0; i < NUM_CMP; i++) begin : g_ch
      assign cmp_evt[i] = live && (cnt == cmp_val[i]);
   end

   // only the designated channel may restart the counter
   assign clear_req = (mode == MODE_CTC) && cmp_evt[CLEAR_CH];

   // R6: a masked or idle cycle produces no compare event
   always_comb begin
      if (!live)
         a_no_evt_r6: assert (cmp_evt == '0);
   end

endmodule

// File: rtl/tmr8_flags.sv
module tmr8_flags #(
   parameter int NUM_SRC  = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_evt,
   input  logic [NUM_SRC-1:0] clr,
   input  logic [NUM_SRC-1:0] ack,
   input  logic [NUM_SRC-1:0] irq_en,
   output logic [NUM_SRC-1:0] flag_q,
   output logic [NUM_SRC-1:0] irq
);

   for (genvar j = 0; j < NUM_SRC; j++) begin : g_flag
      logic drop;
      assign drop = clr[j] || ack[j];

      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_q[j] <= 1'b0;
            else if (set_evt[j])
               flag_q[j] <= 1'b1;
            else if (drop)
               flag_q[j] <= 1'b0;
         end
      end else begin : g_clear_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flag_q[j] <= 1'b0;
            else if (drop)
               flag_q[j] <= 1'b0;
            else if (set_evt[j])
               flag_q[j] <= 1'b1;
         end
      end

      assign irq[j] = flag_q[j] && irq_en[j];

      // R7: a flag stays set until cleared or acknowledged
      p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[j] && !drop) |=> flag_q[j]);

      // R7: a hardware event always leaves the flag set (set wins)
      if (SET_WINS) begin : g_chk_set
         p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[j] |=> flag_q[j]);
      end
   end

endmodule

// File: rtl/tmr8_cc.sv
module tmr8_cc
   import tmr8_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int NUM_CMP  = 2,
   parameter int CLEAR_CH = 0,
   parameter bit SET_WINS = 1'b1,
   localparam int ADDR_W  = $clog2(NUM_CMP + 2),
   localparam int NUM_SRC = NUM_CMP + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic [NUM_SRC-1:0] flag_clr,
   input  logic [NUM_SRC-1:0] irq_ack,
   output logic [CNT_W-1:0]   count,
   output logic               ovf_flag,
   output logic [NUM_CMP-1:0] cmp_flag,
   output logic [NUM_SRC-1:0] irq_req
);

   // elaboration-time parameter checks
   if (CNT_W < 2) begin : g_bad_width
      $error("tmr8_cc: CNT_W must be at least 2");
   end
   if (NUM_CMP < 1) begin : g_bad_ncmp
      $error("tmr8_cc: NUM_CMP must be at least 1");
   end
   if (CLEAR_CH < 0 || CLEAR_CH >= NUM_CMP) begin : g_bad_clr
      $error("tmr8_cc: CLEAR_CH out of range");
   end
   if (CNT_W < NUM_SRC + 1) begin : g_bad_ctrl
      $error("tmr8_cc: control word too narrow for mode and enables");
   end

   logic [NUM_CMP-1:0][CNT_W-1:0] cmp_val;
   tmr_mode_e                     mode;
   logic [NUM_SRC-1:0]            irq_en;
   logic                          cnt_wr;
   logic                          blk;
   logic                          adv;
   logic                          ovf_evt;
   logic                          clear_req;
   logic [NUM_CMP-1:0]            cmp_evt;
   logic [NUM_SRC-1:0]            flags;

   tmr8_regfile #(
      .CNT_W   (CNT_W),
      .NUM_CMP (NUM_CMP),
      .ADDR_W  (ADDR_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cmp_val (cmp_val),
      .mode    (mode),
      .irq_en  (irq_en),
      .cnt_wr  (cnt_wr)
   );

   tmr8_count #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .cnt_wr    (cnt_wr),
      .wr_data   (wr_data),
      .clear_req (clear_req),
      .cnt_q     (count),
      .blk_q     (blk),
      .adv       (adv),
      .ovf_evt   (ovf_evt)
   );

   tmr8_match #(
      .CNT_W    (CNT_W),
      .NUM_CMP  (NUM_CMP),
      .CLEAR_CH (CLEAR_CH)
   ) u_match (
      .adv       (adv),
      .blk       (blk),
      .cnt       (count),
      .cmp_val   (cmp_val),
      .mode      (mode),
      .cmp_evt   (cmp_evt),
      .clear_req (clear_req)
   );

   tmr8_flags #(
      .NUM_SRC  (NUM_SRC),
      .SET_WINS (SET_WINS)
   ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_evt ({cmp_evt, ovf_evt}),
      .clr     (flag_clr),
      .ack     (irq_ack),
      .irq_en  (irq_en),
      .flag_q  (flags),
      .irq     (irq_req)
   );

   assign ovf_flag = flags[0];
   assign cmp_flag = flags[NUM_SRC-1:1];

   // R2: the overflow flag can only rise as the counter lands on zero
   p_ovf_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (count == '0));

   // R3: in clear mode a live tick at the top value returns to zero
   p_ctc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_CTC && adv && !blk && count == cmp_val[CLEAR_CH])
      |=> (count == '0));

   // R6: the first tick after a counter write always increments
   p_masked_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (blk && tick_en && !cnt_wr) |=> (count == $past(count) + 1'b1));

   // R8: no request without its flag
   p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_req & ~flags) == '0));

endmodule

// File: tb/tb_tmr8_cc.sv
`timescale 1ns/100ps
module tb_tmr8_cc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] flag_clr = '0;
   logic [2:0] irq_ack = '0;
   logic [7:0] count;
   logic       ovf_flag;
   logic [1:0] cmp_flag;
   logic [2:0] irq_req;

   always #2.5 clk = ~clk;

   tmr8_cc dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .flag_clr(flag_clr),
      .irq_ack(irq_ack), .count(count), .ovf_flag(ovf_flag),
      .cmp_flag(cmp_flag), .irq_req(irq_req)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   // bench model state
   logic [7:0] m_cnt = '0;
   logic       m_blk = 1'b0;
   logic [2:0] m_flag = '0;
   logic [7:0] m_a = '0, m_b = '0;
   logic [7:0] m_ctrl = '0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      logic [2:0] m_irq;
      m_irq = m_flag & m_ctrl[3:1];
      chk(tag, "count", int'(count), int'(m_cnt));
      chk(tag, "ovf_flag", int'(ovf_flag), int'(m_flag[0]));
      chk(tag, "cmp_flag", int'(cmp_flag), int'(m_flag[2:1]));
      chk(tag, "irq_req", int'(irq_req), int'(m_irq));
   endtask

   // one clock: drive at negedge, update model, check at next negedge
   task automatic step(input logic t, input logic w, input logic [1:0] a,
                       input logic [7:0] d, input logic [2:0] c,
                       input logic [2:0] k, input string tag);
      logic [2:0] set;
      logic       ma, mb;
      tick_en = t; wr_en = w; wr_addr = a; wr_data = d; flag_clr = c; irq_ack = k;
      set = '0;
      if (w && a == 2'd0) begin
         m_cnt = d;
         m_blk = 1'b1;
      end else if (t) begin
         ma = !m_blk && (m_cnt == m_a);
         mb = !m_blk && (m_cnt == m_b);
         set = {mb, ma, (m_cnt == 8'hFF)};
         if (m_ctrl[0] && ma) m_cnt = 8'h00;
         else                 m_cnt = m_cnt + 8'd1;
         m_blk = 1'b0;
      end
      m_flag = (m_flag & ~(c | k)) | set;
      if (w && a == 2'd1) m_a = d;
      if (w && a == 2'd2) m_b = d;
      if (w && a == 2'd3) m_ctrl = d;
      @(negedge clk);
      check_all(tag);
   endtask

   task automatic ticks(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'h00, 3'b000, 3'b000, tag);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
      step(1'b0, 1'b1, a, d, 3'b000, 3'b000, tag);
   endtask

   task automatic clear_flags(input string tag);
      step(1'b0, 1'b0, 2'd0, 8'h00, 3'b111, 3'b000, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R10 reset");

      // R9 register map, enables on, free-running mode
      wr(2'd3, 8'h0E, "R9 ctrl");
      wr(2'd1, 8'h40, "R9 cmpA");
      wr(2'd2, 8'h80, "R9 cmpB");

      // R1/R2/R4: full free-running sweep with periodic acknowledge
      for (int r = 0; r < 6; r++) begin
         ticks(100, "R1 free run");
         step(1'b0, 1'b0, 2'd0, 8'h00, 3'b000, 3'b111, "R7 ack all");
      end

      // R1: irregular tick strobe
      for (int i = 0; i < 60; i++)
         step(i % 3 == 0, 1'b0, 2'd0, 8'h00, 3'b000, 3'b000, "R1 gated tick");

      // R3/R2: clear-on-compare sweep over top values
      for (int v = 0; v < 7; v++) begin
         logic [7:0] top;
         case (v)
            0: top = 8'h00; 1: top = 8'h01; 2: top = 8'h02; 3: top = 8'h07;
            4: top = 8'h80; 5: top = 8'hFE; default: top = 8'hFF;
         endcase
         wr(2'd3, 8'h0F, "R9 ctc on");
         wr(2'd1, top, "R9 top");
         wr(2'd0, 8'h00, "R5 load zero");
         clear_flags("R7 clear");
         for (int p = 0; p < 12; p++) begin
            ticks(50, "R3 ctc sweep");
            step(1'b0, 1'b0, 2'd0, 8'h00, 3'b111, 3'b000, "R7 clr");
         end
      end

      // R4: channel B in clear mode, inside and beyond the period
      wr(2'd1, 8'h20, "R9 A");
      wr(2'd2, 8'h10, "R9 B in range");
      ticks(100, "R4 B no clear");
      wr(2'd2, 8'h30, "R9 B out of range");
      clear_flags("R7 clear");
      ticks(100, "R4 B beyond top");

      // R6: write equal to A in clear mode -> no match, runs past top
      wr(2'd1, 8'h30, "R9 A");
      clear_flags("R7 clear");
      wr(2'd0, 8'h30, "R6 load equal A");
      ticks(1, "R6 masked tick");
      ticks(300, "R6 runs through wrap");

      // R6: mask survives idle cycles; equal to B in free mode
      wr(2'd3, 8'h0E, "R9 free");
      wr(2'd2, 8'h50, "R9 B");
      clear_flags("R7 clear");
      wr(2'd0, 8'h50, "R6 load equal B");
      for (int i = 0; i < 5; i++)
         step(1'b0, 1'b0, 2'd0, 8'h00, 3'b000, 3'b000, "R6 idle");
      ticks(3, "R6 masked after idle");

      // R5: write colliding with tick, including at 0xFF
      step(1'b1, 1'b1, 2'd0, 8'h77, 3'b000, 3'b000, "R5 write wins");
      step(1'b1, 1'b1, 2'd0, 8'hFF, 3'b000, 3'b000, "R5 no ovf on write");
      ticks(2, "R5 then counts");

      // R2: written above A in clear mode rolls through 0xFF
      wr(2'd3, 8'h0F, "R9 ctc");
      wr(2'd1, 8'h10, "R9 A");
      clear_flags("R7 clear");
      wr(2'd0, 8'h20, "R2 load above A");
      ticks(260, "R2 roll then clear");

      // R7: set and clear in the same cycle, set wins
      wr(2'd3, 8'h0E, "R9 free");
      wr(2'd2, 8'h60, "R9 B");
      clear_flags("R7 clear");
      wr(2'd0, 8'h5E, "R7 preload");
      ticks(2, "R7 approach");
      step(1'b1, 1'b0, 2'd0, 8'h00, 3'b100, 3'b100, "R7 set wins");
      step(1'b0, 1'b0, 2'd0, 8'h00, 3'b100, 3'b000, "R7 clr B");
      step(1'b0, 1'b0, 2'd0, 8'h00, 3'b000, 3'b000, "R7 stays clear");

      // R8: enables off, flags still set, no requests; then per-bit
      wr(2'd3, 8'h00, "R8 ie off");
      ticks(300, "R8 masked irq");
      wr(2'd3, 8'h04, "R8 A only");
      ticks(80, "R8 A only");
      wr(2'd3, 8'h0A, "R8 ovf and B");
      ticks(300, "R8 ovf and B");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule